// File: doc/BRIEF.md
# Fractional-Increment PTP Time-of-Day Clock

This block keeps a 64-bit nanosecond time-of-day for precision timestamping. Every cycle of its clock counts as one reference tick. On each tick the raw counter grows by an integer number of nanoseconds, plus one more whenever a 32-bit fractional accumulator carries out. The period is therefore a 32.32 fixed-point value. With a 333,333,333 Hz reference the period is 2^32·10^9 divided by the frequency, which gives an integer part of 3 ns and a fractional addend of 12. Those are the reset values.

Software reaches the block through a 32-bit register bus. It can:
- retune the rate, with the integer and fractional parts changing together;
- load the raw counter;
- apply a 64-bit offset that shifts the reported time without touching the raw count;
- arm two 64-bit alarms whose event flags, gated by a mask, drive one interrupt line.

Every 64-bit quantity is read low word first. The low-word read captures the high word so that the pair is coherent.

The request side is valid/ready. `req_ready` is always high, so a request is accepted in the cycle it is presented and the block never applies back-pressure. A read returns `rsp_valid` with data exactly one cycle after acceptance, and the read data is the register value before that clock edge. Writes produce no response. The response side has no ready, so the requester must take every response.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset the control register reads 0x0003_0000 (integer period 3 in bits [25:16], enable bit 2 clear), the fractional addend reads 12, raw counter, current time and event status read 0, and `irq` is low.
- R2: While the enable bit (control bit 2) is set, each cycle the fractional addend is summed into a 32-bit accumulator and the raw counter grows by the active integer period plus the accumulator carry-out.
- R3: While the enable bit is clear, the raw counter and the accumulator hold their values.
- R4: An integer period written to control bits [25:16] reads back at once but stays pending; the rate uses it only after the fractional addend register (0xA0) is next written.
- R5: Reading the raw-counter low word (0x98) or the current-time low word (0xF0) captures the matching high word; a later read of 0x9C or 0xF4 returns that captured word even if the value has changed since.
- R6: Writing the raw-counter low word (0x98) only stages it; the counter is loaded with {high, staged low} when the high word (0x9C) is written.
- R7: Current time (0xF0/0xF4) equals the raw counter plus the 64-bit offset (0xB0/0xB4), with carry across words; writing the offset leaves the raw counter unchanged.
- R8: Alarm n (low at 0xB8+8n, high at 0xBC+8n) is armed by a write to its high word. On the first cycle in which current time is at least the alarm value, it sets event bit 16+n (register 0x84) once. It then stays inert until its high word is written again.
- R9: Writing 1 to an event bit clears it; when an alarm fires in the same cycle as that clear, the bit ends up set.
- R10: `irq` is high exactly when some event bit is set whose mask bit (register 0x88, same positions) is also set.
- R11: An alarm programmed to all ones (0xFFFF_FFFF_FFFF_FFFF) does not fire while the current time is below that value.
- R12: `req_ready` is always 1. Each read gives exactly one `rsp_valid` pulse one cycle later, writes give none, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every cycle is a tick |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Masked event interrupt |

## Verification
The two functions that collide are an alarm firing and a software write-one-to-clear of the same event bit. The bench re-arms alarm 0 with a value already behind the current time. Because the alarm's armed state is registered, the match lands on the next edge, and the bench places the clearing write on exactly that edge. It then judges by reading the event register: the bit must still be set. A second clear with no firing must then leave it at zero.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int ADDR_W = 8;

  localparam logic [7:0] A_CTRL   = 8'h80;
  localparam logic [7:0] A_EVT    = 8'h84;
  localparam logic [7:0] A_MASK   = 8'h88;
  localparam logic [7:0] A_CNT_LO = 8'h98;
  localparam logic [7:0] A_CNT_HI = 8'h9C;
  localparam logic [7:0] A_FRAC   = 8'hA0;
  localparam logic [7:0] A_OFF_LO = 8'hB0;
  localparam logic [7:0] A_OFF_HI = 8'hB4;
  localparam int         A_ALM0   = 'hB8;
  localparam int         ALM_STEP = 8;
  localparam logic [7:0] A_NOW_LO = 8'hF0;
  localparam logic [7:0] A_NOW_HI = 8'hF4;

  localparam int CTRL_EN_BIT  = 2;
  localparam int CTRL_INT_LSB = 16;
  localparam logic [31:0] CTRL_WMASK = 32'h13FF_8007;
  localparam int EVT_LSB = 16;
endpackage

// File: rtl/ptp_tod_count.sv
module ptp_tod_count #(
  parameter int CNT_W  = 64,
  parameter int INT_W  = 10,
  parameter int FRAC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [INT_W-1:0] per_int,
  input  logic [FRAC_W-1:0] frac,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc_q} + {1'b0, frac};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt   <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (en) begin
      acc_q <= acc_sum[FRAC_W-1:0];
      cnt   <= cnt + CNT_W'(per_int) + CNT_W'(acc_sum[FRAC_W]);
    end
  end
endmodule

// File: rtl/ptp_tod_alarm.sv
module ptp_tod_alarm #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*DW-1:0] now,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic          clr,
  output logic [2*DW-1:0] val,
  output logic          armed,
  output logic          evt
);
  logic fire;

  assign fire = armed && (now >= val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val   <= '1;
      armed <= 1'b0;
      evt   <= 1'b0;
    end else begin
      if (wr_lo) val[DW-1:0]    <= wdata;
      if (wr_hi) val[2*DW-1:DW] <= wdata;
      if (wr_hi)     armed <= 1'b1;
      else if (fire) armed <= 1'b0;
      if (fire)      evt <= 1'b1;
      else if (clr)  evt <= 1'b0;
    end
  end
endmodule

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
  import ptp_tod_pkg::*;
#(
  parameter int DW       = 32,
  parameter int INT_W    = 10,
  parameter int N_ALM    = 2,
  parameter int DEF_INT  = 3,
  parameter int DEF_FRAC = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DW-1:0]               req_wdata,
  input  logic [2*DW-1:0]             raw_cnt,
  input  logic [2*DW-1:0]             now,
  input  logic [N_ALM-1:0][2*DW-1:0]  alm_val,
  input  logic [N_ALM-1:0]            evt,
  output logic                        tmr_en,
  output logic [INT_W-1:0]            per_act,
  output logic [DW-1:0]               frac,
  output logic [2*DW-1:0]             offset,
  output logic                        cnt_load,
  output logic [2*DW-1:0]             cnt_load_val,
  output logic [N_ALM-1:0]            alm_wr_lo,
  output logic [N_ALM-1:0]            alm_wr_hi,
  output logic [N_ALM-1:0]            evt_clr,
  output logic [N_ALM-1:0]            mask,
  output logic                        rsp_valid,
  output logic [DW-1:0]               rsp_rdata
);
  localparam logic [DW-1:0] CTRL_RST = DW'(DEF_INT) << CTRL_INT_LSB;

  logic          wr, rd;
  logic [DW-1:0] ctrl_q, cnt_stage, snap_cnt, snap_now, rdata;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  assign tmr_en       = ctrl_q[CTRL_EN_BIT];
  assign cnt_load     = wr && (req_addr == A_CNT_HI);
  assign cnt_load_val = {req_wdata, cnt_stage};

  for (genvar g = 0; g < N_ALM; g++) begin : g_strobe
    assign alm_wr_lo[g] = wr && (req_addr == ADDR_W'(A_ALM0 + ALM_STEP * g));
    assign alm_wr_hi[g] = wr && (req_addr == ADDR_W'(A_ALM0 + ALM_STEP * g + 4));
    assign evt_clr[g]   = wr && (req_addr == A_EVT) && req_wdata[EVT_LSB + g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RST;
      per_act   <= INT_W'(DEF_INT);
      frac      <= DW'(DEF_FRAC);
      offset    <= '0;
      cnt_stage <= '0;
      mask      <= '0;
    end else if (wr) begin
      case (req_addr)
        A_CTRL:   ctrl_q <= req_wdata & CTRL_WMASK;
        A_FRAC: begin
          frac    <= req_wdata;
          per_act <= ctrl_q[CTRL_INT_LSB +: INT_W];
        end
        A_OFF_LO: offset[DW-1:0]    <= req_wdata;
        A_OFF_HI: offset[2*DW-1:DW] <= req_wdata;
        A_CNT_LO: cnt_stage <= req_wdata;
        A_MASK:   mask <= req_wdata[EVT_LSB +: N_ALM];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_cnt <= '0;
      snap_now <= '0;
    end else if (rd) begin
      if (req_addr == A_CNT_LO) snap_cnt <= raw_cnt[2*DW-1:DW];
      if (req_addr == A_NOW_LO) snap_now <= now[2*DW-1:DW];
    end
  end

  always_comb begin
    rdata = '0;
    case (req_addr)
      A_CTRL:   rdata = ctrl_q;
      A_EVT:    rdata = DW'(evt) << EVT_LSB;
      A_MASK:   rdata = DW'(mask) << EVT_LSB;
      A_CNT_LO: rdata = raw_cnt[DW-1:0];
      A_CNT_HI: rdata = snap_cnt;
      A_FRAC:   rdata = frac;
      A_OFF_LO: rdata = offset[DW-1:0];
      A_OFF_HI: rdata = offset[2*DW-1:DW];
      A_NOW_LO: rdata = now[DW-1:0];
      A_NOW_HI: rdata = snap_now;
      default:  rdata = '0;
    endcase
    for (int i = 0; i < N_ALM; i++) begin
      if (req_addr == ADDR_W'(A_ALM0 + ALM_STEP * i))     rdata = alm_val[i][DW-1:0];
      if (req_addr == ADDR_W'(A_ALM0 + ALM_STEP * i + 4)) rdata = alm_val[i][2*DW-1:DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rdata;
    end
  end
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import ptp_tod_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int INT_W    = 10,
  parameter int N_ALM    = 2,
  parameter int DEF_INT  = 3,
  parameter int DEF_FRAC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic                          tmr_en, cnt_load;
  logic [INT_W-1:0]              per_act;
  logic [DATA_W-1:0]             frac;
  logic [CNT_W-1:0]              offset, cnt_load_val, raw_cnt, now;
  logic [N_ALM-1:0][CNT_W-1:0]   alm_val;
  logic [N_ALM-1:0]              alm_wr_lo, alm_wr_hi, evt_clr, mask_bits, evt_bits, alm_armed;

  assign req_ready = 1'b1;
  assign now       = raw_cnt + offset;
  assign irq       = |(evt_bits & mask_bits);

  ptp_tod_regs #(
    .DW(DATA_W), .INT_W(INT_W), .N_ALM(N_ALM), .DEF_INT(DEF_INT), .DEF_FRAC(DEF_FRAC)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .raw_cnt(raw_cnt), .now(now), .alm_val(alm_val), .evt(evt_bits),
    .tmr_en(tmr_en), .per_act(per_act), .frac(frac), .offset(offset),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .alm_wr_lo(alm_wr_lo), .alm_wr_hi(alm_wr_hi), .evt_clr(evt_clr), .mask(mask_bits),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  ptp_tod_count #(.CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .per_int(per_act), .frac(frac),
    .load(cnt_load), .load_val(cnt_load_val), .cnt(raw_cnt)
  );

  for (genvar g = 0; g < N_ALM; g++) begin : g_alm
    ptp_tod_alarm #(.DW(DATA_W)) u_alarm (
      .clk(clk), .rst_n(rst_n), .now(now),
      .wr_lo(alm_wr_lo[g]), .wr_hi(alm_wr_hi[g]), .wdata(req_wdata), .clr(evt_clr[g]),
      .val(alm_val[g]), .armed(alm_armed[g]), .evt(evt_bits[g])
    );
  end
endmodule

// File: rtl/ptp_tod_checker.sv
module ptp_tod_checker #(
  parameter int CNT_W = 64,
  parameter int INT_W = 10,
  parameter int N_ALM = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             irq,
  input logic             tmr_en,
  input logic             cnt_load,
  input logic [CNT_W-1:0] raw_cnt,
  input logic [INT_W-1:0] per_act,
  input logic [N_ALM-1:0] evt,
  input logic [N_ALM-1:0] mask,
  input logic [N_ALM-1:0] armed,
  input logic [N_ALM-1:0] arm_wr
);
  // R2: an enabled tick adds the period or the period plus one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && !cnt_load) |=>
      (((raw_cnt - $past(raw_cnt)) == CNT_W'($past(per_act))) ||
       ((raw_cnt - $past(raw_cnt)) == CNT_W'($past(per_act)) + 1)));

  // R3: disabled counter holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !cnt_load) |=> $stable(raw_cnt));

  // R10: interrupt only with some mask bit set
  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|mask));

  // R12: one response per read, none otherwise
  p_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  p_norsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R8: a fresh event leaves its alarm disarmed
  for (genvar g = 0; g < N_ALM; g++) begin : g_chk
    p_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(evt[g]) && !$past(arm_wr[g])) |-> !armed[g]);
  end
endmodule

bind ptp_tod_clock ptp_tod_checker #(.CNT_W(2 * DATA_W), .INT_W(INT_W), .N_ALM(N_ALM)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .irq(irq), .tmr_en(tmr_en), .cnt_load(cnt_load),
  .raw_cnt(raw_cnt), .per_act(per_act), .evt(evt_bits), .mask(mask_bits),
  .armed(alm_armed), .arm_wr(alm_wr_hi)
);

// File: tb/ptp_tod_clock_test.sv
module ptp_tod_clock_test;
  localparam logic [7:0] CTRL = 8'h80, EVT = 8'h84, MSK = 8'h88, CLO = 8'h98, CHI = 8'h9C,
                         FRC = 8'hA0, OLO = 8'hB0, OHI = 8'hB4, A0L = 8'hB8, A0H = 8'hBC,
                         A1L = 8'hC0, A1H = 8'hC4, NLO = 8'hF0, NHI = 8'hF4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [63:0] m_cnt = 0, m_off = 0, alm;
  logic [31:0] m_acc = 0, m_frac = 12;
  logic [9:0]  m_int = 3, pend = 3;

  ptp_tod_clock uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R12 unexpected response", 1, 0);
      else begin
        string t;
        logic [31:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rsp_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      logic [32:0] s;
      s = {1'b0, m_acc} + {1'b0, m_frac};
      m_acc = s[31:0];
      m_cnt = m_cnt + 64'(m_int) + 64'(s[32]);
    end
  endtask

  // exactly k enabled ticks
  task automatic run(input int k);
    wr(CTRL, (32'(pend) << 16) | 32'h4);
    idle(k - 1);
    wr(CTRL, 32'(pend) << 16);
    model_ticks(k);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    rd(CTRL, 32'h0003_0000, "R1 ctrl reset");
    rd(FRC, 32'd12, "R1 frac reset");
    rd(CLO, 0, "R1 counter reset");
    rd(NLO, 0, "R1 time reset");
    rd(EVT, 0, "R1 event reset");

    // R2 default rate
    run(4);
    rd(CLO, m_cnt[31:0], "R2 default rate low");
    rd(CHI, m_cnt[63:32], "R2 default rate high");

    // R4 staged period
    wr(CTRL, 32'd5 << 16); pend = 5;
    rd(CTRL, 32'h0005_0000, "R4 pending readback");
    run(3);
    rd(CLO, m_cnt[31:0], "R4 old period still active");
    wr(FRC, 32'h8000_0000); m_int = 5; m_frac = 32'h8000_0000;
    run(5);
    rd(CLO, m_cnt[31:0], "R2 fractional carry");

    // R3 hold while disabled
    idle(6);
    rd(CLO, m_cnt[31:0], "R3 hold while disabled");

    // R6 staged load
    wr(CLO, 32'h3333_4444);
    rd(CLO, m_cnt[31:0], "R6 low write alone no load");
    wr(CHI, 32'h1111_2222); m_cnt = 64'h1111_2222_3333_4444;
    // R5 snapshot
    rd(CLO, 32'h3333_4444, "R5 low read");
    wr(CLO, 0); wr(CHI, 32'h5555_6666); m_cnt = 64'h5555_6666_0000_0000;
    rd(CHI, 32'h1111_2222, "R5 high from snapshot");
    rd(CLO, 0, "R6 loaded low");
    rd(CHI, 32'h5555_6666, "R6 loaded high");

    // R7 offset
    wr(CLO, 32'hFFFF_FFF8); wr(CHI, 0); m_cnt = 64'hFFFF_FFF8;
    wr(OLO, 32'h10); wr(OHI, 32'h1); m_off = 64'h1_0000_0010;
    rd(NLO, 32'h8, "R7 time low with carry");
    rd(NHI, 32'h2, "R7 time high");
    rd(CLO, 32'hFFFF_FFF8, "R7 raw untouched low");
    rd(CHI, 0, "R7 raw untouched high");

    // R8 alarm
    wr(FRC, 0); m_frac = 0;
    alm = m_cnt + m_off + 20;
    wr(A0L, alm[31:0]); wr(A0H, alm[63:32]);
    rd(EVT, 0, "R8 no fire before time");
    run(5);
    rd(EVT, 32'h0001_0000, "R8 fires at time");
    wr(EVT, 32'h0001_0000);
    run(3);
    rd(EVT, 0, "R8 inert after firing");

    // R9 fire and clear in the same cycle
    wr(A0H, alm[63:32]);
    wr(EVT, 32'h0001_0000);
    rd(EVT, 32'h0001_0000, "R9 set wins over clear");

    // R10 interrupt masking
    wr(MSK, 0);
    chk("R10 irq masked", irq, 0);
    wr(MSK, 32'h0001_0000);
    chk("R10 irq unmasked", irq, 1);
    rd(MSK, 32'h0001_0000, "R10 mask readback");
    wr(EVT, 32'h0001_0000);
    chk("R10 irq after clear", irq, 0);
    rd(EVT, 0, "R9 clear without fire");

    // R11 all-ones alarm
    wr(A1L, 32'hFFFF_FFFF); wr(A1H, 32'hFFFF_FFFF);
    run(4);
    rd(EVT, 0, "R11 all-ones alarm silent");
    rd(A1L, 32'hFFFF_FFFF, "R11 alarm readback");
    rd(NLO, 32'(m_cnt + m_off), "R7 time after counting");

    // R12 bus
    chk("R12 ready", req_ready, 1);
    rd(8'h40, 0, "R12 unmapped read");
    idle(2);
    chk("R12 responses outstanding", exp_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule